// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block decides when an SDRAM controller owes the memory an auto-refresh command. A down-counter running from the system clock marks each refresh interval. Every time it runs out, one more refresh is owed, and the block asks the command arbiter for a slot. The controller sends only the refresh command; the memory steps through its rows on its own. When the arbiter grants the slot, a second down-counter times the recovery period that the memory needs after the command. The block reports busy until that counter reaches zero.

Two device profiles are built in. The slow one spreads 4096 refreshes over 64 ms, which is about one every 15.6 us. The fast one spreads 4096 refreshes over 16 ms, which is about one every 3.9 us. Either profile can be replaced by a raw interval given in clock cycles. Refreshes that fall due while an earlier one is still waiting are queued and then served back to back. Each such late expiry is counted, so that the system can see how much refresh it is postponing.

Top module: `rfsh_scheduler`

## Requirements
- R1: Reset is synchronous and active low. Right after reset, `req_o` and `busy_o` are 0 and `miss_cnt_o` is 0.
- R2: With `raw_en_i`=0 and `prof_sel_i`=0, refreshes fall due every floor(SLOW_MS * CLK_KHZ / ROWS) cycles. With the defaults this is 1562 cycles. The first one falls due that many cycles after reset is released.
- R3: With `raw_en_i`=0 and `prof_sel_i`=1, refreshes fall due every floor(FAST_MS * CLK_KHZ / ROWS) cycles. With the defaults this is 390 cycles.
- R4: With `raw_en_i`=1, the interval is `raw_ivl_i` cycles. Values 0 and 1 are treated as 2.
- R5: `req_o` stays high until a cycle in which `grant_i` is high. In the next cycle `req_o` is low and `busy_o` is high.
- R6: After a grant, `busy_o` stays high for exactly `rec_cycles_i` cycles. A value of 0 counts as 1. `req_o` is never high while `busy_o` is high.
- R7: The interval counter reloads in the cycle a refresh falls due, not in the cycle it is granted. A late grant therefore does not move the later due times.
- R8: Each time a refresh falls due while at least one refresh is still owed, `miss_cnt_o` goes up by one. It saturates at all ones.
- R9: Owed refreshes are granted one after another, each after the previous recovery. At most PEND_MAX (default 8) are held; any further due refreshes are dropped.
- R10: A change of profile or raw interval takes effect only at the next reload. The interval already running completes at its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prof_sel_i | input | 1 | Profile: 0 = 4096 rows / 64 ms, 1 = 4096 rows / 16 ms |
| raw_en_i | input | 1 | 1 = use `raw_ivl_i` in place of the profile |
| raw_ivl_i | input | CNT_W | Raw refresh interval in clock cycles |
| rec_cycles_i | input | REC_W | Recovery time after a granted refresh, in cycles |
| grant_i | input | 1 | Arbiter has issued the refresh command this cycle |
| req_o | output | 1 | A refresh is owed and the memory is not recovering |
| busy_o | output | 1 | Recovery period after a refresh is running |
| miss_cnt_o | output | MISS_W | Saturating count of refreshes that fell due while one was still owed |

## Verification
The checks assume that the arbiter raises `grant_i` only while `req_o` is high. They also assume that reset is held for at least two clock edges, so that the history-based checks start from settled counters. The stimulus drives grant only in a cycle where it has just seen `req_o` high, and it holds reset for five cycles. It changes `raw_ivl_i` only at chosen points within an interval, so that the reload rule can be seen at the outputs.

// File: rtl/rfsh_pkg.sv
// Package: shared types for the refresh scheduler.
// Assumes: nothing; pure type and constant definitions.
package rfsh_pkg;

    // Selects which device refresh profile drives the interval counter.
    typedef enum logic {
        PROF_64MS = 1'b0,
        PROF_16MS = 1'b1
    } rfsh_prof_e;

    // Shortest interval the timer accepts, in cycles.
    localparam int unsigned MIN_IVL = 2;

endpackage

// File: rtl/rfsh_interval_timer.sv
// Module: rfsh_interval_timer
// Counts down the refresh interval and pulses expire_o once per interval.
// The length is taken from the selected profile or from a raw value.
// It is sampled only when the counter reloads.
// Assumes: SLOW_IVL and FAST_IVL fit in CNT_W bits and are at least 2.
module rfsh_interval_timer
    import rfsh_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned SLOW_IVL = 1562,
    parameter int unsigned FAST_IVL = 390
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prof_sel_i,
    input  logic             raw_en_i,
    input  logic [CNT_W-1:0] raw_ivl_i,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] IVL_MIN  = CNT_W'(MIN_IVL);
    localparam logic [CNT_W-1:0] IVL_SLOW = CNT_W'(SLOW_IVL);
    localparam logic [CNT_W-1:0] IVL_FAST = CNT_W'(FAST_IVL);

    logic [CNT_W-1:0] sel_ivl;
    logic [CNT_W-1:0] cnt_q;

    // Picks the interval that applies at the next reload.
    always_comb begin
        if (raw_en_i) begin
            sel_ivl = (raw_ivl_i < IVL_MIN) ? IVL_MIN : raw_ivl_i;
        end else if (prof_sel_i == PROF_16MS) begin
            sel_ivl = IVL_FAST;
        end else begin
            sel_ivl = IVL_SLOW;
        end
    end

    // Counts down and reloads on expiry, whether or not the refresh is granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= sel_ivl - 1'b1;
        end else if (cnt_q == '0) begin
            cnt_q <= sel_ivl - 1'b1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = (cnt_q == '0);

    // R4: the interval is never shorter than two cycles.
    p_expire_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);

endmodule

// File: rtl/rfsh_pending_tracker.sv
// Module: rfsh_pending_tracker
// Keeps the number of owed refreshes, up to PEND_MAX.
// Also keeps a saturating count of expiries that arrive while a refresh is still owed.
// Assumes: take_i is raised only while owed_o is high.
module rfsh_pending_tracker #(
    parameter int unsigned PEND_MAX = 8,
    parameter int unsigned MISS_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire_i,
    input  logic              take_i,
    output logic              owed_o,
    output logic [MISS_W-1:0] miss_cnt_o
);

    localparam int unsigned     PW   = $clog2(PEND_MAX + 1);
    localparam logic [PW-1:0]   PMAX = PW'(PEND_MAX);

    logic [PW-1:0]     pend_q;
    logic [MISS_W-1:0] miss_q;
    logic              add;

    assign add = expire_i && (pend_q != PMAX);

    // Adds an owed refresh on expiry and removes one when granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            case ({add, take_i})
                2'b10:   pend_q <= pend_q + 1'b1;
                2'b01:   pend_q <= pend_q - 1'b1;
                default: pend_q <= pend_q;
            endcase
        end
    end

    // Counts expiries that land while an earlier refresh is still owed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_q <= '0;
        end else if (expire_i && (pend_q != '0) && (miss_q != '1)) begin
            miss_q <= miss_q + 1'b1;
        end
    end

    assign owed_o     = (pend_q != '0);
    assign miss_cnt_o = miss_q;

    // R9: the queue never exceeds its depth.
    p_pend_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= PMAX);

    // R5: a grant is only taken against an owed refresh.
    p_take_owed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> owed_o);

    // R8: the missed-refresh count never goes down outside reset.
    p_miss_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> miss_q >= $past(miss_q));

endmodule

// File: rtl/rfsh_recovery_timer.sv
// Module: rfsh_recovery_timer
// Loads the recovery time on a granted refresh and counts it down to zero.
// Reports busy while the count is not zero.
// Assumes: start_i is not raised while busy_o is high.
module rfsh_recovery_timer #(
    parameter int unsigned REC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [REC_W-1:0] rec_cycles_i,
    output logic             busy_o
);

    logic [REC_W-1:0] cnt_q;
    logic [REC_W-1:0] load_val;

    // A zero recovery time still blocks for one cycle.
    assign load_val = (rec_cycles_i == '0) ? REC_W'(1) : rec_cycles_i;

    // Loads on a grant, then counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = (cnt_q != '0);

    // R6: a granted refresh is always followed by a busy cycle.
    p_busy_after_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    // R6: no new start while recovery is running.
    p_no_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !start_i);

endmodule

// File: rtl/rfsh_scheduler.sv
// Module: rfsh_scheduler (top)
// Periodic auto-refresh scheduler for an SDRAM controller.
// It requests refreshes, queues those that fall due while others are waiting,
// and times the recovery that follows each granted refresh.
// Assumes: grant_i is high only while req_o is high.
module rfsh_scheduler #(
    parameter int unsigned CLK_KHZ  = 100000,
    parameter int unsigned ROWS     = 4096,
    parameter int unsigned SLOW_MS  = 64,
    parameter int unsigned FAST_MS  = 16,
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned REC_W    = 8,
    parameter int unsigned MISS_W   = 8,
    parameter int unsigned PEND_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prof_sel_i,
    input  logic              raw_en_i,
    input  logic [CNT_W-1:0]  raw_ivl_i,
    input  logic [REC_W-1:0]  rec_cycles_i,
    input  logic              grant_i,
    output logic              req_o,
    output logic              busy_o,
    output logic [MISS_W-1:0] miss_cnt_o
);

    // Rounded down, so the deadline is never missed.
    localparam int unsigned SLOW_IVL = (SLOW_MS * CLK_KHZ) / ROWS;
    localparam int unsigned FAST_IVL = (FAST_MS * CLK_KHZ) / ROWS;

    logic expire;
    logic owed;
    logic take;

    assign take  = req_o && grant_i;
    assign req_o = owed && !busy_o;

    rfsh_interval_timer #(
        .CNT_W    (CNT_W),
        .SLOW_IVL (SLOW_IVL),
        .FAST_IVL (FAST_IVL)
    ) u_ivl (
        .clk        (clk),
        .rst_n      (rst_n),
        .prof_sel_i (prof_sel_i),
        .raw_en_i   (raw_en_i),
        .raw_ivl_i  (raw_ivl_i),
        .expire_o   (expire)
    );

    rfsh_pending_tracker #(
        .PEND_MAX (PEND_MAX),
        .MISS_W   (MISS_W)
    ) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire_i   (expire),
        .take_i     (take),
        .owed_o     (owed),
        .miss_cnt_o (miss_cnt_o)
    );

    rfsh_recovery_timer #(
        .REC_W (REC_W)
    ) u_rec (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (take),
        .rec_cycles_i (rec_cycles_i),
        .busy_o       (busy_o)
    );

    // R5: an ungranted request is held.
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !grant_i) |=> req_o);

    // R5: a granted request drops in the next cycle.
    p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && grant_i) |=> !req_o);

endmodule

// File: tb/rfsh_scheduler_tb_top.sv
module rfsh_scheduler_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SLOW_EXP   = (64 * 100000) / 4096;
    localparam int FAST_EXP   = (16 * 100000) / 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prof_sel = 1'b0;
    logic        raw_en = 1'b0;
    logic [15:0] raw_ivl = 16'd100;
    logic [7:0]  rec_cycles = 8'd2;
    logic        grant = 1'b0;
    logic        req;
    logic        busy;
    logic [7:0]  miss_cnt;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rfsh_scheduler dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .prof_sel_i   (prof_sel),
        .raw_en_i     (raw_en),
        .raw_ivl_i    (raw_ivl),
        .rec_cycles_i (rec_cycles),
        .grant_i      (grant),
        .req_o        (req),
        .busy_o       (busy),
        .miss_cnt_o   (miss_cnt)
    );

    task automatic check_eq(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(output int t_rel);
        grant = 1'b0;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_rel = cyc;
    endtask

    task automatic wait_req(output int t);
        while (!req) @(negedge clk);
        t = cyc;
    endtask

    task automatic serve_one();
        grant = 1'b1;
        @(negedge clk);
        grant = 1'b0;
    endtask

    task automatic serve_all(int ncyc, output int n, output int overlap);
        n = 0;
        overlap = 0;
        for (int i = 0; i < ncyc; i++) begin
            if (req && busy) overlap++;
            if (req) begin
                n++;
                grant = 1'b1;
            end else begin
                grant = 1'b0;
            end
            @(negedge clk);
        end
        grant = 1'b0;
    endtask

    task automatic t_reset_state();
        int tr;
        raw_en = 1'b1; raw_ivl = 16'd100;
        do_reset(tr);
        check_eq("R1 req after reset", int'(req), 0);
        check_eq("R1 busy after reset", int'(busy), 0);
        check_eq("R1 miss after reset", int'(miss_cnt), 0);
    endtask

    task automatic t_profile(bit fast, int exp_ivl, string tag);
        int tr, t0, t1;
        raw_en = 1'b0; prof_sel = fast; rec_cycles = 8'd2;
        do_reset(tr);
        wait_req(t0);
        check_eq({tag, " first due"}, t0 - tr, exp_ivl);
        serve_one();
        wait_req(t1);
        check_eq({tag, " period"}, t1 - t0, exp_ivl);
        serve_one();
    endtask

    task automatic t_hold_and_late_grant();
        int tr, t0, t1;
        bit held = 1'b1;
        raw_en = 1'b1; raw_ivl = 16'd30; rec_cycles = 8'd2;
        do_reset(tr);
        wait_req(t0);
        for (int i = 0; i < 7; i++) begin
            if (!req) held = 1'b0;
            @(negedge clk);
        end
        check_eq("R5 req held without grant", int'(held), 1);
        serve_one();
        check_eq("R5 req low after grant", int'(req), 0);
        check_eq("R5 busy after grant", int'(busy), 1);
        wait_req(t1);
        check_eq("R7 due time unaffected by late grant", t1 - t0, 30);
        serve_one();
    endtask

    task automatic t_recovery(int rec, int exp_len);
        int tr, t0, n;
        bit clean = 1'b1;
        raw_en = 1'b1; raw_ivl = 16'd40; rec_cycles = 8'(rec);
        do_reset(tr);
        wait_req(t0);
        serve_one();
        n = 0;
        while (busy && n < 300) begin
            if (req) clean = 1'b0;
            n++;
            @(negedge clk);
        end
        check_eq($sformatf("R6 busy length rec=%0d", rec), n, exp_len);
        check_eq("R6 no req while busy", int'(clean), 1);
    endtask

    task automatic t_backlog();
        int tr, t0, n, ov;
        raw_en = 1'b1; raw_ivl = 16'd10; rec_cycles = 8'd3;
        do_reset(tr);
        wait_req(t0);
        repeat (25) @(negedge clk);
        raw_ivl = 16'd1000;
        repeat (5) @(negedge clk);
        check_eq("R8 miss count after three late expiries", int'(miss_cnt), 3);
        serve_all(60, n, ov);
        check_eq("R9 owed refreshes served back to back", n, 4);
        check_eq("R6 req and busy never together", ov, 0);
    endtask

    task automatic t_backlog_cap();
        int tr, t0, n, ov;
        raw_en = 1'b1; raw_ivl = 16'd4; rec_cycles = 8'd1;
        do_reset(tr);
        wait_req(t0);
        repeat (40) @(negedge clk);
        raw_ivl = 16'd1000;
        repeat (5) @(negedge clk);
        check_eq("R8 miss counts dropped expiries too", int'(miss_cnt), 11);
        serve_all(100, n, ov);
        check_eq("R9 queue capped at 8", n, 8);
    endtask

    task automatic t_reload_rule();
        int tr, t0, t1, t2;
        raw_en = 1'b1; raw_ivl = 16'd50; rec_cycles = 8'd2;
        do_reset(tr);
        wait_req(t0);
        serve_one();
        raw_ivl = 16'd20;
        wait_req(t1);
        check_eq("R10 running interval keeps old length", t1 - t0, 50);
        serve_one();
        wait_req(t2);
        check_eq("R10 new length after reload", t2 - t1, 20);
        serve_one();
        raw_en = 1'b0; prof_sel = 1'b1;
        wait_req(t0);
        check_eq("R10 profile switch waits for reload", t0 - t2, 20);
        serve_one();
        wait_req(t1);
        check_eq("R3 profile after run-time switch", t1 - t0, FAST_EXP);
        serve_one();
    endtask

    task automatic t_clamp_and_saturate();
        int tr, t0;
        raw_en = 1'b1; raw_ivl = 16'd0; rec_cycles = 8'd1;
        do_reset(tr);
        wait_req(t0);
        check_eq("R4 raw 0 treated as 2", t0 - tr, 2);
        repeat (20) @(negedge clk);
        check_eq("R4 R8 expiry every 2 cycles", int'(miss_cnt), 10);
        repeat (600) @(negedge clk);
        check_eq("R8 miss count saturates", int'(miss_cnt), 255);
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_profile(1'b0, SLOW_EXP, "R2");
        t_profile(1'b1, FAST_EXP, "R3");
        t_hold_and_late_grant();
        t_recovery(4, 4);
        t_recovery(0, 1);
        t_backlog();
        t_backlog_cap();
        t_reload_rule();
        t_clamp_and_saturate();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (R1 to R10 run): actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule